// File: doc/BRIEF.md
# Parameter-Block Command Controller

This block is the host-side control logic of a disk controller that takes its commands as parameter blocks held in memory. The host loads a 16-bit block address and a 16-bit relocation value through byte-wide registers, then sets a go bit. The controller fetches the block, passes it to a stub executor that waits a fixed number of cycles, writes a completion word back into the block, and follows the chain link to the next block if the block asks for it. When the chain ends, it clears busy and can raise an interrupt-pending flag.

While a chain runs, the host can ask for attention. The controller then stops at the next block boundary and acknowledges. The host can edit memory during this pause, for example to append blocks to the tail of the chain. The controller resumes once the host drops its request. A write to the reset register aborts everything at once. Memory traffic uses a single 16-bit request/acknowledge port, and every access has a bounded wait for the acknowledge.

Top module: `pbc_host_ctl`

## Requirements
- R1: The host registers are byte wide. Offset 0 holds relocation bits 7:0, offset 1 relocation bits 15:8, offset 2 block address bits 7:0 and offset 3 block address bits 15:8. Each reads back what was written. Offset 4 is the reset register and offset 5 the control/status register.
- R2: After reset the control/status register reads 0x01 when the drive-ready input is high. Its bits are 7 busy, 6 error, 5 double error, 4 interrupt pending, 3 24-bit mode, 2 attention request, 1 attention acknowledge and 0 drive ready. No memory request is issued.
- R3: Writing control/status with bit 7 set while idle starts a chain. Busy stays high until the chain ends, and memory requests occur only while busy.
- R4: Memory addresses are byte addresses and every access is one 16-bit word. Block word 0 carries the command code in bits 3:0, interrupt enable in bit 4 and chain enable in bit 5. At completion the controller writes the word at block offset 2 as: bit 0 done = 1, bit 7 error summary, bits 15:8 completion code. The code is 0x00 for every implemented command.
- R5: Command code 0xD completes with code 0x15. This sets the error bit and ends the chain without following the link.
- R6: After a successful block, the controller re-reads word 0. If chain enable is set, it reads the next block address from block offset 0x12 and uses the same relocation.
- R7: Interrupt pending is set when the chain ends if the last block has interrupt enable set. It is also set after each block whose word 0 bit 14 is set. An interrupt enable on a non-final block has no effect.
- R8: Writing control/status with bit 4 set clears interrupt pending, and the irq output follows that bit.
- R9: If attention request is set while busy, the controller stops after the current block's status write. It raises attention acknowledge and issues no memory request until the host clears attention request. It then resumes by re-reading the current block's word 0.
- R10: If a read is not acknowledged within ACK_TIMEOUT cycles, the block completes with code 0x0E and the error bit is set. If the status write of a failed block is also lost, the double-error bit is set as well.
- R11: Any write to the reset register returns the controller to idle on the next clock. It clears busy, error, double error, interrupt pending and attention, and no status word is written.
- R12: The memory address is {relocation, block address} plus the field offset. With 24-bit mode set, address bits 31:24 are forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 3 | Host register offset |
| regWrData | input | 8 | Host write data |
| regRdData | output | 8 | Host read data for regAddr (combinational) |
| driveReady | input | 1 | Drive ready, mirrored in status bit 0 |
| memReq | output | 1 | Memory request, held until acknowledge or timeout |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the 16-bit word |
| memWrData | output | 16 | Write data (completion word) |
| memAck | input | 1 | Memory acknowledge, one-cycle pulse |
| memRdData | input | 16 | Read data, valid with memAck |
| irqOut | output | 1 | Interrupt pending |

## Verification
The assertions check several rules on every cycle. Memory requests happen only while busy. A go write while idle raises busy. A paused controller keeps the memory port quiet and only acknowledges a request that was pending. A reset-register write leaves the controller idle with no interrupt pending. A write-one to the interrupt bit clears it. Other behaviour can only be shown by the bench's scenarios: the contents of the completion word, the way links are followed through memory, appending a block during a pause, which block's enable decides the end-of-chain interrupt, and the single and double timeout failures.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int ADDR_W = 32;

  localparam logic [2:0] REG_RELOC_LO = 3'd0;
  localparam logic [2:0] REG_BASE_LO  = 3'd2;
  localparam logic [2:0] REG_RESET    = 3'd4;
  localparam logic [2:0] REG_CSR      = 3'd5;

  localparam logic [7:0] CODE_OK     = 8'h00;
  localparam logic [7:0] CODE_BADCMD = 8'h15;
  localparam logic [7:0] CODE_NOACK  = 8'h0E;
  localparam logic [3:0] CMD_RSVD    = 4'hD;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h02;
  localparam logic [7:0] OFS_LINK = 8'h12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_STATUS, ST_HOLD, ST_RECHK, ST_LINK
  } pbcState_t;

  typedef struct packed {
    logic loadBase;
    logic loadCmd;
    logic loadLink;
    logic clrCnt;
    logic forceNoAck;
  } pbcStrobe_t;
endpackage

// File: rtl/pbc_datapath.sv
module pbc_datapath
  import pbc_pkg::*;
#(
  parameter int ACK_TIMEOUT = 16,
  parameter int EXEC_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  pbcStrobe_t        strobe,
  input  logic [15:0]       memRdData,
  input  logic [7:0]        byteOffset,
  input  logic              adrMode,
  output logic [15:0]       relocReg,
  output logic [15:0]       baseReg,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       statusWord,
  output logic [7:0]        code,
  output logic              cmdIen,
  output logic              cmdIei,
  output logic              ackTimeout,
  output logic              execDone
);
  localparam int CNT_MAX = (ACK_TIMEOUT > EXEC_CYCLES) ? ACK_TIMEOUT : EXEC_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [15:0]       blkAddr;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] rawAddr;

  // host byte lanes: offset n+0 is the low byte, n+1 the high byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relocReg <= '0;
      baseReg  <= '0;
    end else if (regWrEn) begin
      for (int b = 0; b < 2; b++) begin
        if (regAddr == REG_RELOC_LO + 3'(b)) relocReg[8*b +: 8] <= regWrData;
        if (regAddr == REG_BASE_LO + 3'(b))  baseReg[8*b +: 8]  <= regWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkAddr <= '0;
      code    <= CODE_OK;
      cmdIen  <= 1'b0;
      cmdIei  <= 1'b0;
      cnt     <= '0;
    end else begin
      if (strobe.loadBase) blkAddr <= baseReg;
      else if (strobe.loadLink) blkAddr <= memRdData;
      if (strobe.forceNoAck) begin
        code   <= CODE_NOACK;
        cmdIen <= 1'b0;
        cmdIei <= 1'b0;
      end else if (strobe.loadCmd) begin
        code   <= (memRdData[3:0] == CMD_RSVD) ? CODE_BADCMD : CODE_OK;
        cmdIen <= memRdData[4];
        cmdIei <= memRdData[14];
      end
      if (strobe.clrCnt) cnt <= '0;
      else if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
    end
  end

  assign rawAddr    = {relocReg, blkAddr} + ADDR_W'(byteOffset);
  assign memAddr    = adrMode ? {8'h00, rawAddr[23:0]} : rawAddr;
  assign statusWord = {code, (code != CODE_OK), 6'b0, 1'b1};
  assign ackTimeout = (cnt == CNT_W'(ACK_TIMEOUT - 1));
  assign execDone   = (cnt == CNT_W'(EXEC_CYCLES - 1));
endmodule

// File: rtl/pbc_control.sv
module pbc_control
  import pbc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csrWr,
  input  logic       rstWr,
  input  logic       wrGo,
  input  logic       wrIrqClr,
  input  logic       wrAdr,
  input  logic       wrAttn,
  input  logic       memAck,
  input  logic       linkFlag,
  input  logic       cmdIen,
  input  logic       cmdIei,
  input  logic [7:0] code,
  input  logic       ackTimeout,
  input  logic       execDone,
  output pbcStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic [7:0] byteOffset,
  output logic       busy,
  output logic       errFlag,
  output logic       dblErr,
  output logic       irqPend,
  output logic       attnReq,
  output logic       attnAck,
  output logic       adrMode
);
  pbcState_t state, nxt;
  logic finish, blkDone, stepErr, stepDbl, codeBad;

  assign codeBad = (code != CODE_OK);

  always_comb begin
    nxt     = state;
    strobe  = '0;
    finish  = 1'b0;
    blkDone = 1'b0;
    stepErr = 1'b0;
    stepDbl = 1'b0;
    case (state)
      ST_IDLE:
        if (csrWr && wrGo) begin
          strobe.loadBase = 1'b1;
          strobe.clrCnt   = 1'b1;
          nxt             = ST_FETCH;
        end
      ST_FETCH:
        if (memAck) begin
          strobe.loadCmd = 1'b1;
          strobe.clrCnt  = 1'b1;
          nxt            = ST_EXEC;
        end else if (ackTimeout) begin
          strobe.forceNoAck = 1'b1;
          strobe.clrCnt     = 1'b1;
          nxt               = ST_STATUS;
        end
      ST_EXEC:
        if (execDone) begin
          strobe.clrCnt = 1'b1;
          nxt           = ST_STATUS;
        end
      ST_STATUS:
        if (memAck || ackTimeout) begin
          blkDone       = 1'b1;
          strobe.clrCnt = 1'b1;
          if (!memAck || codeBad) begin
            stepErr = 1'b1;
            stepDbl = !memAck && codeBad;
            finish  = 1'b1;
          end else if (attnReq) nxt = ST_HOLD;
          else nxt = ST_RECHK;
        end
      ST_HOLD:
        if (!attnReq) begin
          strobe.clrCnt = 1'b1;
          nxt           = ST_RECHK;
        end
      ST_RECHK:
        if (memAck) begin
          strobe.clrCnt = 1'b1;
          if (linkFlag) nxt = ST_LINK;
          else finish = 1'b1;
        end else if (ackTimeout) begin
          stepErr = 1'b1;
          finish  = 1'b1;
        end
      ST_LINK:
        if (memAck) begin
          strobe.loadLink = 1'b1;
          strobe.clrCnt   = 1'b1;
          nxt             = ST_FETCH;
        end else if (ackTimeout) begin
          stepErr = 1'b1;
          finish  = 1'b1;
        end
      default: nxt = ST_IDLE;
    endcase
    if (finish) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
      dblErr  <= 1'b0;
      irqPend <= 1'b0;
      attnReq <= 1'b0;
      adrMode <= 1'b0;
    end else if (rstWr) begin
      state   <= ST_IDLE;
      errFlag <= 1'b0;
      dblErr  <= 1'b0;
      irqPend <= 1'b0;
      attnReq <= 1'b0;
    end else begin
      state <= nxt;
      if (csrWr) begin
        adrMode <= wrAdr;
        attnReq <= wrAttn;
        if (wrIrqClr) irqPend <= 1'b0;
      end
      if (state == ST_IDLE && csrWr && wrGo) begin
        errFlag <= 1'b0;
        dblErr  <= 1'b0;
      end
      if (stepErr) errFlag <= 1'b1;
      if (stepDbl) dblErr <= 1'b1;
      if ((blkDone && cmdIei) || (finish && cmdIen)) irqPend <= 1'b1;
    end
  end

  assign busy       = (state != ST_IDLE);
  assign attnAck    = (state == ST_HOLD);
  assign memReq     = state inside {ST_FETCH, ST_STATUS, ST_RECHK, ST_LINK};
  assign memWe      = (state == ST_STATUS);
  assign byteOffset = (state == ST_LINK) ? OFS_LINK :
                      (state == ST_STATUS) ? OFS_STAT : OFS_CMD;
endmodule

// File: rtl/pbc_host_ctl.sv
module pbc_host_ctl
  import pbc_pkg::*;
#(
  parameter int ACK_TIMEOUT = 16,
  parameter int EXEC_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        driveReady,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [15:0] memWrData,
  input  logic        memAck,
  input  logic [15:0] memRdData,
  output logic        irqOut
);
  pbcStrobe_t strobe;
  logic [15:0] relocReg, baseReg;
  logic [7:0]  code, byteOffset, csrVal;
  logic csrWr, rstWr, cmdIen, cmdIei, ackTimeout, execDone;
  logic busy, errFlag, dblErr, irqPend, attnReq, attnAck, adrMode;

  assign csrWr = regWrEn && (regAddr == REG_CSR);
  assign rstWr = regWrEn && (regAddr == REG_RESET);

  pbc_datapath #(.ACK_TIMEOUT(ACK_TIMEOUT), .EXEC_CYCLES(EXEC_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(strobe), .memRdData(memRdData),
    .byteOffset(byteOffset), .adrMode(adrMode), .relocReg(relocReg),
    .baseReg(baseReg), .memAddr(memAddr), .statusWord(memWrData),
    .code(code), .cmdIen(cmdIen), .cmdIei(cmdIei),
    .ackTimeout(ackTimeout), .execDone(execDone)
  );

  pbc_control u_ctl (
    .clk(clk), .rstN(rstN), .csrWr(csrWr), .rstWr(rstWr),
    .wrGo(regWrData[7]), .wrIrqClr(regWrData[4]), .wrAdr(regWrData[3]),
    .wrAttn(regWrData[2]), .memAck(memAck), .linkFlag(memRdData[5]),
    .cmdIen(cmdIen), .cmdIei(cmdIei), .code(code),
    .ackTimeout(ackTimeout), .execDone(execDone), .strobe(strobe),
    .memReq(memReq), .memWe(memWe), .byteOffset(byteOffset), .busy(busy),
    .errFlag(errFlag), .dblErr(dblErr), .irqPend(irqPend),
    .attnReq(attnReq), .attnAck(attnAck), .adrMode(adrMode)
  );

  assign csrVal = {busy, errFlag, dblErr, irqPend, adrMode, attnReq, attnAck, driveReady};
  assign irqOut = irqPend;

  always_comb begin
    case (regAddr)
      3'd0:    regRdData = relocReg[7:0];
      3'd1:    regRdData = relocReg[15:8];
      3'd2:    regRdData = baseReg[7:0];
      3'd3:    regRdData = baseReg[15:8];
      REG_CSR: regRdData = csrVal;
      default: regRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/pbc_host_ctl_chk.sv
module pbc_host_ctl_chk (
  input logic clk,
  input logic rstN,
  input logic csrWr,
  input logic rstWr,
  input logic wrGo,
  input logic wrIrqClr,
  input logic memReq,
  input logic busy,
  input logic irqPend,
  input logic attnReq,
  input logic attnAck
);
  // R3
  mem_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R3
  go_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrWr && wrGo && !busy |=> busy);

  // R9
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    attnAck |-> busy && !memReq);

  // R9
  ack_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(attnAck) |-> $past(attnReq));

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstWr |=> !busy && !irqPend && !attnAck);

  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    csrWr && wrIrqClr && !busy |=> !irqPend);
endmodule

bind pbc_host_ctl pbc_host_ctl_chk u_chk (
  .clk(clk), .rstN(rstN), .csrWr(csrWr), .rstWr(rstWr),
  .wrGo(regWrData[7]), .wrIrqClr(regWrData[4]), .memReq(memReq),
  .busy(busy), .irqPend(irqPend), .attnReq(attnReq), .attnAck(attnAck)
);

// File: tb/sim_pbc_host_ctl.sv
`timescale 1ns/1ps
module sim_pbc_host_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd5;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic driveReady = 1'b1;
  logic memReq, memWe, memAck, irqOut;
  logic [31:0] memAddr;
  logic [15:0] memWrData, memRdData;

  logic [15:0] mem [0:255];
  logic pokeEn = 1'b0;
  logic [7:0] pokeIdx = 8'h00;
  logic [15:0] pokeData = 16'h0000;
  logic dropRd = 1'b0;
  logic dropAll = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pbc_host_ctl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .driveReady(driveReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWrData(memWrData),
    .memAck(memAck), .memRdData(memRdData), .irqOut(irqOut)
  );

  // memory model: one-cycle acknowledge, word index from byte address bits 8:1
  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else memAck <= memReq && !memAck && !dropAll && !(dropRd && !memWe);
    if (pokeEn) mem[pokeIdx] <= pokeData;
    else if (memReq && !memAck && memWe && !dropAll) mem[memAddr[8:1]] <= memWrData;
    memRdData <= mem[memAddr[8:1]];
  end

  typedef struct packed {
    logic [3:0] cmd;
    logic       ien;
    logic       iei;
    logic [7:0] code;
    logic       err;
    logic       irq;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'h2, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1},
    '{4'h1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{4'hD, 1'b1, 1'b0, 8'h15, 1'b1, 1'b1},
    '{4'h5, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
    '{4'hD, 1'b0, 1'b0, 8'h15, 1'b1, 1'b0},
    '{4'hF, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 3'd5;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic poke(input logic [7:0] idx, input logic [15:0] d);
    @(negedge clk);
    pokeIdx = idx; pokeData = d; pokeEn = 1'b1;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic putBlock(input logic [8:0] base, input logic [15:0] w0, input logic [15:0] link);
    poke(base[8:1], w0);
    poke(base[8:1] + 8'd1, 16'h0000);
    poke(base[8:1] + 8'd9, link);
  endtask

  task automatic startAt(input logic [15:0] base, input logic [7:0] csr);
    regWrite(3'd2, base[7:0]);
    regWrite(3'd3, base[15:8]);
    regWrite(3'd5, csr);
  endtask

  task automatic waitIdle();
    regAddr = 3'd5;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!regRdData[7]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd, r0, r1, r2, r3;
    logic quiet;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    regRead(3'd5, rd);
    check("R2 reset csr", rd, 8'h01);
    check("R2 reset memReq", memReq, 1'b0);

    regWrite(3'd0, 8'h34); regWrite(3'd1, 8'h12);
    regWrite(3'd2, 8'hC0); regWrite(3'd3, 8'h01);
    regRead(3'd0, r0); regRead(3'd1, r1); regRead(3'd2, r2); regRead(3'd3, r3);
    check("R1 byte lanes", {r1, r0, r3, r2}, 32'h123401C0);
    regWrite(3'd0, 8'h00); regWrite(3'd1, 8'h00);

    // table of single-block commands: R4 R5 R7
    for (int v = 0; v < 6; v++) begin
      putBlock(9'h040, {1'b0, VECS[v].iei, 6'b0, 3'b000, VECS[v].ien, VECS[v].cmd}, 16'h0000);
      startAt(16'h0040, 8'h80);
      waitIdle();
      check($sformatf("R4 R5 status word v%0d", v), mem[8'h21],
            {16'h0, VECS[v].code, VECS[v].err, 6'b0, 1'b1});
      regRead(3'd5, rd);
      check($sformatf("R5 R7 csr v%0d", v), rd,
            {1'b0, VECS[v].err, 1'b0, VECS[v].irq, 3'b000, 1'b1});
      check($sformatf("R7 irqOut v%0d", v), irqOut, VECS[v].irq);
      regWrite(3'd4, 8'h00);
    end

    // R8 write-one clears interrupt pending
    putBlock(9'h040, 16'h0012, 16'h0000);
    startAt(16'h0040, 8'h80);
    waitIdle();
    regWrite(3'd5, 8'h10);
    regRead(3'd5, rd);
    check("R8 ipnd cleared", {rd, 7'b0, irqOut}, {8'h01, 8'h00});

    // R6 R7 three-block chain, interrupt from final block
    putBlock(9'h040, 16'h0022, 16'h0080);
    putBlock(9'h080, 16'h0021, 16'h00C0);
    putBlock(9'h0C0, 16'h0015, 16'h0000);
    startAt(16'h0040, 8'h80);
    waitIdle();
    check("R6 chain status", {mem[8'h21], mem[8'h41]}, 32'h00010001);
    check("R6 chain last status", mem[8'h61], 16'h0001);
    regRead(3'd5, rd);
    check("R7 chain end irq", rd, 8'h11);
    regWrite(3'd4, 8'h00);

    // R7 enable on a non-final block has no effect
    putBlock(9'h040, 16'h0032, 16'h0080);
    putBlock(9'h080, 16'h0001, 16'h0000);
    startAt(16'h0040, 8'h80);
    waitIdle();
    regRead(3'd5, rd);
    check("R7 non-final ien", rd, 8'h01);
    check("R6 second block done", mem[8'h41], 16'h0001);

    // R7 per-block interrupt from the first block
    putBlock(9'h040, 16'h4022, 16'h0080);
    putBlock(9'h080, 16'h0001, 16'h0000);
    startAt(16'h0040, 8'h80);
    waitIdle();
    regRead(3'd5, rd);
    check("R7 each-block irq", rd, 8'h11);
    regWrite(3'd4, 8'h00);

    // R5 reserved command stops the chain
    putBlock(9'h040, 16'h002D, 16'h0080);
    putBlock(9'h080, 16'h0001, 16'h0000);
    startAt(16'h0040, 8'h80);
    waitIdle();
    check("R5 chain stopped", {mem[8'h21], mem[8'h41]}, 32'h15810000);
    regWrite(3'd4, 8'h00);

    // R9 attention pause and append
    putBlock(9'h040, 16'h0002, 16'h0000);
    putBlock(9'h080, 16'h0011, 16'h0000);
    startAt(16'h0040, 8'h84);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (regRdData[1]) break;
    end
    regRead(3'd5, rd);
    check("R9 ack while busy", {rd[7], rd[2], rd[1]}, 3'b111);
    quiet = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (memReq) quiet = 1'b0;
    end
    check("R9 no memory while paused", quiet, 1'b1);
    poke(8'h20, 16'h0022);
    poke(8'h29, 16'h0080);
    regWrite(3'd5, 8'h00);
    waitIdle();
    check("R9 appended block done", mem[8'h41], 16'h0001);
    regRead(3'd5, rd);
    check("R9 resumed to end", rd, 8'h11);
    regWrite(3'd4, 8'h00);

    // R10 read timeout
    putBlock(9'h040, 16'h0012, 16'h0000);
    dropRd = 1'b1;
    startAt(16'h0040, 8'h80);
    waitIdle();
    check("R10 timeout code", mem[8'h21], 16'h0E81);
    regRead(3'd5, rd);
    check("R10 single error csr", rd, 8'h41);
    dropRd = 1'b0;
    regWrite(3'd4, 8'h00);

    // R10 read and status write both lost
    poke(8'h21, 16'h0000);
    dropAll = 1'b1;
    startAt(16'h0040, 8'h80);
    waitIdle();
    regRead(3'd5, rd);
    check("R10 double error csr", rd, 8'h61);
    check("R10 no status written", mem[8'h21], 16'h0000);
    dropAll = 1'b0;
    regWrite(3'd4, 8'h00);

    // R11 abort during a block
    putBlock(9'h040, 16'h0012, 16'h0000);
    startAt(16'h0040, 8'h84);
    regRead(3'd5, rd);
    check("R11 busy before abort", rd[7], 1'b1);
    regWrite(3'd4, 8'h00);
    regRead(3'd5, rd);
    check("R11 idle after abort", {rd, 7'b0, memReq}, {8'h01, 8'h00});
    repeat (20) @(negedge clk);
    check("R11 no status after abort", mem[8'h21], 16'h0000);

    // R12 relocation and 24-bit mode
    regWrite(3'd0, 8'h12); regWrite(3'd1, 8'hAB);
    startAt(16'h0040, 8'h80);
    check("R12 full address", memAddr, 32'hAB120040);
    regWrite(3'd4, 8'h00);
    startAt(16'h0040, 8'h88);
    check("R12 24-bit address", memAddr, 32'h00120040);
    regWrite(3'd4, 8'h00);
    regRead(3'd5, rd);
    check("R1 R12 mode bit kept", rd, 8'h09);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule